// File: doc/BRIEF.md
# Timestamped Sample Capture FIFO

This block sits between a single converter channel and the bus-side reader. Each 14-bit conversion result arrives with a one-cycle valid strobe. The block pairs the sample with the current value of a local 17-bit timer and packs both into one 32-bit word. The word goes into a four-entry first-in-first-out store.

A reader pulls words out one at a time with a read strobe and can watch the fill level at any moment. The timer can be started, held, forced to zero and given a wrap point. Its running value is visible on an output.

Four single-cycle event pulses report the store's condition changes to an interrupt collector outside the block:
- the store has become full;
- the store has become empty;
- a write was lost;
- a read found nothing.

Top module: `ts_capture_fifo`

## Requirements
- R1: A stored word holds the sample in bits [13:0] and, in bits [31:14], the timer count from the cycle in which `smp_valid` was high, zero-extended to 18 bits.
- R2: Words leave in the order they were written, and the store keeps up to four of them.
- R3: `fill_level` (3 bits) reports the number of held words, from 0 to 4. A write and a read in the same cycle on a store holding 1 to 3 words leave the level unchanged.
- R4: A write while four words are held is dropped and the stored words are unchanged. `evt_overflow` is high for exactly the one cycle that follows the dropped write.
- R5: A read while the store is empty sets `rd_data` to zero and leaves the level at 0. `evt_underflow` is high for exactly the one cycle that follows that read.
- R6: `evt_full` is high for one cycle: the first cycle in which the level reads 4 after having been lower.
- R7: `evt_empty` is high for one cycle: the first cycle in which the level reads 0 after having been higher.
- R8: The timer count rises by one on each clock edge while `tmr_enable` is 1, and holds its value while `tmr_enable` is 0.
- R9: While `tmr_clear` is 1, the count goes to zero on the next edge, whatever the value of `tmr_enable`.
- R10: Only bits [16:0] of `tmr_limit` are used, and bits [23:17] have no effect. With a non-zero limit, the count returns to zero on the edge after it equals the limit. With a zero limit, it runs through all 17-bit values and wraps from 131071 to 0.
- R11: After reset, the level, `rd_data`, the timer count and all four event outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample present this cycle; write request |
| smp_data | input | 14 | Converter sample |
| rd_strobe | input | 1 | Read request |
| rd_data | output | 32 | Last word read: {timestamp, sample}; zero after a read of an empty store |
| fill_level | output | 3 | Words currently held |
| tmr_enable | input | 1 | Timer advances when 1 |
| tmr_clear | input | 1 | Timer forced to zero when 1 |
| tmr_limit | input | 24 | Wrap point; low 17 bits used, 0 means full range |
| tmr_count | output | 17 | Current timer value |
| evt_full | output | 1 | One-cycle pulse on entering full |
| evt_empty | output | 1 | One-cycle pulse on entering empty |
| evt_overflow | output | 1 | One-cycle pulse after a dropped write |
| evt_underflow | output | 1 | One-cycle pulse after a read of an empty store |

## Verification
The bench builds the block with its default parameters: a depth of four, a 17-bit timer and a 24-bit limit field.

At depth four, the full and overflow paths are reached after only a handful of writes. The timer width is small enough that a complete free-running pass from 0 to 131071 and back to zero fits in one run. The bench also uses a limit whose upper seven bits are set, which shows that those bits are discarded.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int SAMPLE_W = 14;
  localparam int STAMP_W  = 18;
  localparam int WORD_W   = SAMPLE_W + STAMP_W;
  localparam int TIMER_W  = 17;
  localparam int CFG_W    = 24;

  // Packs one capture word: timestamp above, sample below.
  function automatic logic [WORD_W-1:0] pack_word(input logic [SAMPLE_W-1:0] smp,
                                                  input logic [STAMP_W-1:0]  stamp);
    return {stamp, smp};
  endfunction

  // Next timer value given the current count and the active wrap limit.
  function automatic logic [TIMER_W-1:0] timer_next(input logic [TIMER_W-1:0] cur,
                                                    input logic [TIMER_W-1:0] lim);
    if (lim != '0 && cur == lim) return '0;
    return cur + 1'b1;
  endfunction
endpackage

// File: rtl/ts_stamp_timer.sv
module ts_stamp_timer
  import ts_cap_pkg::*;
#(
  parameter int TW = TIMER_W,
  parameter int CW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          clear,
  input  logic [CW-1:0] limit_cfg,
  output logic [TW-1:0] count
);
  logic [TW-1:0] limit_eff;
  logic          unused_cfg_hi;
  logic          wrap_hit;

  assign limit_eff     = limit_cfg[TW-1:0];
  assign unused_cfg_hi = ^limit_cfg[CW-1:TW];
  assign wrap_hit      = enable && !clear && limit_eff != '0 && count == limit_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (enable) count <= timer_next(count, limit_eff);
  end

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> count == '0); // R9
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable && !clear) |-> $stable(count)); // R8
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable && !clear && !wrap_hit) |-> count == TW'($past(count) + 1'b1)); // R8
  AST_TMR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrap_hit) |-> count == '0); // R10
endmodule

// File: rtl/ts_word_fifo.sv
module ts_word_fifo #(
  parameter int WW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_req,
  input  logic [WW-1:0]                wr_word,
  input  logic                         rd_req,
  output logic [WW-1:0]                rd_word,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full_evt,
  output logic                         empty_evt,
  output logic                         ovf_evt,
  output logic                         unf_evt
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  logic [WW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          is_full, is_empty;
  logic          wr_ok, rd_ok, wr_drop, rd_miss;
  logic [LW-1:0] level_nxt;

  assign is_full   = level == LVL_MAX;
  assign is_empty  = level == '0;
  assign wr_ok     = wr_req && !is_full;
  assign wr_drop   = wr_req && is_full;
  assign rd_ok     = rd_req && !is_empty;
  assign rd_miss   = rd_req && is_empty;
  assign level_nxt = level + LW'(wr_ok) - LW'(rd_ok);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mem[e] <= '0;
      else if (wr_ok && wr_ptr == PW'(e))           mem[e] <= wr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      rd_word   <= '0;
      full_evt  <= 1'b0;
      empty_evt <= 1'b0;
      ovf_evt   <= 1'b0;
      unf_evt   <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) begin
        rd_ptr  <= rd_ptr + 1'b1;
        rd_word <= mem[rd_ptr];
      end else if (rd_miss) begin
        rd_word <= '0;
      end
      level     <= level_nxt;
      full_evt  <= level_nxt == LVL_MAX && !is_full;
      empty_evt <= level_nxt == '0 && !is_empty;
      ovf_evt   <= wr_drop;
      unf_evt   <= rd_miss;
    end
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_MAX); // R3
  AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_req && rd_req && level != '0 && level != LVL_MAX) |-> level == $past(level)); // R3
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_req && !rd_req && level == LVL_MAX) |-> level == LVL_MAX && ovf_evt); // R4
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |-> rd_word == '0 && level <= 3'(1)); // R5
  AST_FULL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |-> level == LVL_MAX && $past(level) != LVL_MAX); // R6
  AST_EMPTY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |-> level == '0 && $past(level) != '0); // R7
endmodule

// File: rtl/ts_capture_fifo.sv
module ts_capture_fifo
  import ts_cap_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          smp_valid,
  input  logic [SAMPLE_W-1:0]           smp_data,
  input  logic                          rd_strobe,
  output logic [WORD_W-1:0]             rd_data,
  output logic [$clog2(DEPTH+1)-1:0]    fill_level,
  input  logic                          tmr_enable,
  input  logic                          tmr_clear,
  input  logic [CFG_W-1:0]              tmr_limit,
  output logic [TIMER_W-1:0]            tmr_count,
  output logic                          evt_full,
  output logic                          evt_empty,
  output logic                          evt_overflow,
  output logic                          evt_underflow
);
  logic [STAMP_W-1:0] stamp_now;
  logic [WORD_W-1:0]  cap_word;

  ts_stamp_timer #(.TW(TIMER_W), .CW(CFG_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (tmr_enable),
    .clear     (tmr_clear),
    .limit_cfg (tmr_limit),
    .count     (tmr_count)
  );

  assign stamp_now = STAMP_W'(tmr_count);
  assign cap_word  = pack_word(smp_data, stamp_now);

  ts_word_fifo #(.WW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (smp_valid),
    .wr_word   (cap_word),
    .rd_req    (rd_strobe),
    .rd_word   (rd_data),
    .level     (fill_level),
    .full_evt  (evt_full),
    .empty_evt (evt_empty),
    .ovf_evt   (evt_overflow),
    .unf_evt   (evt_underflow)
  );
endmodule

// File: tb/ts_capture_fifo_test.sv
`timescale 1ns/1ps
module ts_capture_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_data = '0;
  logic        rd_strobe = 1'b0;
  logic [31:0] rd_data;
  logic [2:0]  fill_level;
  logic        tmr_enable = 1'b0;
  logic        tmr_clear = 1'b0;
  logic [23:0] tmr_limit = '0;
  logic [16:0] tmr_count;
  logic        evt_full, evt_empty, evt_overflow, evt_underflow;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ts_capture_fifo uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [13:0] d);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pop();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic timer_zero();
    tmr_clear = 1'b1;
    @(negedge clk);
    tmr_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk(fill_level == 0 && rd_data == 0, "R11 level/data", {fill_level, rd_data}, 0);
    chk(tmr_count == 0, "R11 count", tmr_count, 0);
    chk({evt_full, evt_empty, evt_overflow, evt_underflow} == 0, "R11 events",
        {evt_full, evt_empty, evt_overflow, evt_underflow}, 0);
  endtask

  task automatic t_timer_basic();
    tmr_limit = 0; timer_zero();
    chk(tmr_count == 0, "R9 clear", tmr_count, 0);
    tmr_enable = 1'b1; tick(10);
    chk(tmr_count == 10, "R8 advance", tmr_count, 10);
    tmr_enable = 1'b0; tick(5);
    chk(tmr_count == 10, "R8 hold", tmr_count, 10);
    tmr_enable = 1'b1; tmr_clear = 1'b1; tick(2);
    chk(tmr_count == 0, "R9 clear over enable", tmr_count, 0);
    tmr_clear = 1'b0; tmr_enable = 1'b0;
  endtask

  task automatic t_timer_limit();
    tmr_limit = 24'hFE_0003;
    timer_zero();
    tmr_enable = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick(1);
      chk(tmr_count == 17'(k % 4), "R10 limit wrap, upper bits ignored", tmr_count, k % 4);
    end
    tmr_enable = 1'b0; tmr_limit = 0;
  endtask

  task automatic t_timer_freerun();
    tmr_limit = 0; timer_zero(); tmr_enable = 1'b1;
    tick(131071);
    chk(tmr_count == 17'h1FFFF, "R10 full range top", tmr_count, 17'h1FFFF);
    tick(1);
    chk(tmr_count == 0, "R10 full range wrap", tmr_count, 0);
    tmr_enable = 1'b0;
  endtask

  task automatic t_stamp();
    tmr_limit = 0; timer_zero(); tmr_enable = 1'b1;
    tick(7);
    push(14'h1ABC);           // stamped with count 7
    tick(2);
    push(14'h3FFF);           // stamped with count 10
    tmr_enable = 1'b0;
    chk(fill_level == 2, "R3 level after two writes", fill_level, 2);
    pop();
    chk(rd_data == {18'd7, 14'h1ABC}, "R1 first word", rd_data, {18'd7, 14'h1ABC});
    pop();
    chk(rd_data == {18'd10, 14'h3FFF}, "R1 R2 second word", rd_data, {18'd10, 14'h3FFF});
    chk(evt_empty == 1'b1 && fill_level == 0, "R7 empty pulse", {evt_empty, fill_level}, 4'b1000);
    tick(1);
    chk(evt_empty == 1'b0, "R7 single cycle", evt_empty, 0);
  endtask

  task automatic t_fill_overflow();
    timer_zero(); tmr_enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      push(14'(16'h100 + i));
      chk(fill_level == 3'(i + 1), "R3 level rise", fill_level, i + 1);
      chk(evt_full == (i == 3), "R6 full only on fourth", evt_full, i == 3);
    end
    tick(1);
    chk(evt_full == 1'b0, "R6 single cycle", evt_full, 0);
    push(14'h2222);
    chk(evt_overflow == 1'b1 && fill_level == 4, "R4 overflow drop",
        {evt_overflow, fill_level}, 4'b1100);
    tick(1);
    chk(evt_overflow == 1'b0, "R4 single cycle", evt_overflow, 0);
    for (int i = 0; i < 4; i++) begin
      pop();
      chk(rd_data == {18'd0, 14'(16'h100 + i)}, "R2 R4 order, dropped word absent",
          rd_data, 16'h100 + i);
    end
    chk(fill_level == 0 && evt_empty, "R7 empty after drain", {evt_empty, fill_level}, 4'b1000);
  endtask

  task automatic t_underflow();
    chk(rd_data != 0, "R5 precondition nonzero data", rd_data, 1);
    pop();
    chk(rd_data == 0, "R5 underflow data zero", rd_data, 0);
    chk(evt_underflow == 1'b1 && fill_level == 0, "R5 underflow pulse",
        {evt_underflow, fill_level}, 4'b1000);
    chk(evt_empty == 1'b0, "R7 no pulse when already empty", evt_empty, 0);
    tick(1);
    chk(evt_underflow == 1'b0, "R5 single cycle", evt_underflow, 0);
  endtask

  task automatic t_simultaneous();
    push(14'h0011); push(14'h0022);
    smp_valid = 1'b1; smp_data = 14'h0033; rd_strobe = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; rd_strobe = 1'b0;
    chk(fill_level == 2, "R3 balanced read and write", fill_level, 2);
    chk(rd_data[13:0] == 14'h0011, "R2 balanced read returns oldest", rd_data[13:0], 14'h0011);
    pop(); pop();
    chk(rd_data[13:0] == 14'h0033, "R2 balanced write stored", rd_data[13:0], 14'h0033);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timer_basic();
    t_timer_limit();
    t_stamp();
    t_fill_overflow();
    t_underflow();
    t_simultaneous();
    t_timer_freerun();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule